// File: doc/BRIEF.md
# Bridge Handshake Change Tracer

This block watches the two scheduling wires of up to four bus bridges: the "has data" request each bridge raises and the "hold off" command it receives from the central arbiter. Once every microsecond it takes a snapshot of all eight lines. Whenever a snapshot differs from the one before it, the block builds a five-byte record. The record holds the microsecond count at which the change was seen and the new line states.

Records are queued in a small on-chip FIFO and streamed out of a single asynchronous serial pin. A logging host can then rebuild the exact timeline of grants and requests. The microsecond counter is 31 bits wide and rolls over without notice. If the queue fills up during a burst of activity, the records that do not fit are discarded. The first record accepted afterwards carries a flag, so the gap is visible in the log.

Top module: `hs_trace_top`

## Requirements
- R1: After reset the serial line `tx_o` rests at 1, and no frame is sent while no line has changed.
- R2: The timestamp counts sampling instants. Instant k (k = 0, 1, 2, ...) falls CLK_PER_US·(k+1) clock cycles after reset is released, and a record created at instant k carries timestamp k.
- R3: A record is produced only when the synchronized line vector at an instant differs from the vector at the previous instant. Before the first instant, the previous vector is taken as all zeros. A repeated value produces nothing.
- R4: A record is 5 bytes sent in this order. Byte 0 bit 7 is the overflow flag. Byte 0 bits 6:0 followed by bytes 1, 2 and 3 form the 31-bit timestamp, most significant bits first. Byte 4 holds the request line of bridge i in bit i and the hold-off line of bridge i in bit 4+i; bits for absent bridges read 0.
- R5: Each byte goes out as one start bit (0), eight data bits least significant first and one stop bit (1). Each bit lasts BAUD_DIV clock cycles.
- R6: Records leave in the order they were created, and up to FIFO_DEPTH records can wait behind the one being sent.
- R7: A record created while the FIFO is full is dropped. The next record that is stored has its overflow flag set to 1. Records stored after that carry flag 0 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rdy_i | input | NUM_BR | Data-ready request line of each bridge (asynchronous) |
| blk_i | input | NUM_BR | Hold-off command line of each bridge (asynchronous) |
| tx_o | output | 1 | Serial record stream, idle high |

## Verification
The hardest condition to reach from the ports is the overflow. It needs the FIFO full and a further change arriving while the serializer is still busy with an older record. The bench runs a fast baud divisor and a four-entry FIFO, then toggles the lines on seven consecutive microseconds. The first record is already being sent, the next four fill the queue, and the last two must be lost. A later isolated change must then appear with the flag set, and the change after it must appear with the flag clear.

// File: rtl/hs_trace_pkg.sv
package hs_trace_pkg;
  localparam int TS_W      = 31;
  localparam int SIG_W     = 8;
  localparam int REC_W     = 1 + TS_W + SIG_W;
  localparam int REC_BYTES = REC_W / 8;

  typedef struct packed {
    logic             ovf;
    logic [TS_W-1:0]  ts;
    logic [SIG_W-1:0] sig;
  } trace_rec_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_SEND,
    SQ_WAIT
  } seq_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/hs_sampler.sv
module hs_sampler
  import hs_trace_pkg::*;
#(
  parameter int CLK_PER_US = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SIG_W-1:0] vec_i,
  output logic             rec_v_o,
  output logic [TS_W-1:0]  rec_ts_o,
  output logic [SIG_W-1:0] rec_sig_o
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic [CW-1:0]    div_q;
  logic             tick;
  logic [TS_W-1:0]  ts_q;
  logic [SIG_W-1:0] prev_q;

  assign tick = (div_q == CW'(CLK_PER_US - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= '0;
      ts_q      <= '0;
      prev_q    <= '0;
      rec_v_o   <= 1'b0;
      rec_ts_o  <= '0;
      rec_sig_o <= '0;
    end else begin
      rec_v_o <= 1'b0;
      if (tick) begin
        div_q  <= '0;
        ts_q   <= ts_q + 1'b1;
        prev_q <= vec_i;
        if (vec_i != prev_q) begin
          rec_v_o   <= 1'b1;
          rec_ts_o  <= ts_q;
          rec_sig_o <= vec_i;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R2: the microsecond count moves by exactly one per sampling instant
  assert_ts_step_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> (ts_q == $past(ts_q) + 31'd1));
  assert_ts_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ts_q));
endmodule

// File: rtl/hs_rec_fifo.sv
module hs_rec_fifo #(
  parameter int W     = 40,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_i,
  output logic [W-1:0] rd_data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wp_q] <= wr_data_i;
    if (rd_en_i) rd_data_o <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en_i) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (rd_en_i) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({wr_en_i, rd_en_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |-> !full_o);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |-> !empty_o);
endmodule

// File: rtl/hs_uart_tx.sv
module hs_uart_tx #(
  parameter int BAUD_DIV = 434
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       tx_o,
  output logic       busy_o
);
  localparam int BW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;

  logic [BW-1:0] baud_q;
  logic [8:0]    sh_q;
  logic [3:0]    left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_o   <= 1'b1;
      busy_o <= 1'b0;
      baud_q <= '0;
      sh_q   <= '1;
      left_q <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        tx_o   <= 1'b0;
        sh_q   <= {1'b1, data_i};
        left_q <= 4'd9;
        baud_q <= '0;
        busy_o <= 1'b1;
      end
    end else if (baud_q == BW'(BAUD_DIV - 1)) begin
      baud_q <= '0;
      if (left_q == 4'd0) begin
        busy_o <= 1'b0;
      end else begin
        tx_o   <= sh_q[0];
        sh_q   <= {1'b1, sh_q[8:1]};
        left_q <= left_q - 1'b1;
      end
    end else begin
      baud_q <= baud_q + 1'b1;
    end
  end

  assert_start_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_o);
  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> tx_o);
endmodule

// File: rtl/hs_trace_top.sv
module hs_trace_top
  import hs_trace_pkg::*;
#(
  parameter int NUM_BR     = 4,
  parameter int CLK_PER_US = 50,
  parameter int BAUD_DIV   = 434,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_BR-1:0] rdy_i,
  input  logic [NUM_BR-1:0] blk_i,
  output logic              tx_o
);
  localparam int HALF = SIG_W / 2;

  logic [SIG_W-1:0] raw_vec, sync_vec;

  generate
    for (genvar i = 0; i < HALF; i++) begin : g_pack
      if (i < NUM_BR) begin : g_used
        assign raw_vec[i]      = rdy_i[i];
        assign raw_vec[HALF+i] = blk_i[i];
      end else begin : g_pad
        assign raw_vec[i]      = 1'b0;
        assign raw_vec[HALF+i] = 1'b0;
      end
    end
  endgenerate

  hs_sync #(.W(SIG_W)) i_sync (
    .clk(clk), .rst(rst), .d_i(raw_vec), .q_o(sync_vec)
  );

  logic             rec_v;
  logic [TS_W-1:0]  rec_ts;
  logic [SIG_W-1:0] rec_sig;

  hs_sampler #(.CLK_PER_US(CLK_PER_US)) i_sampler (
    .clk(clk), .rst(rst), .vec_i(sync_vec),
    .rec_v_o(rec_v), .rec_ts_o(rec_ts), .rec_sig_o(rec_sig)
  );

  logic       lost_q, wr_en, rd_en, full, empty;
  trace_rec_t wr_rec;
  logic [REC_W-1:0] rd_word;

  assign wr_en  = rec_v && !full;
  assign wr_rec = '{ovf: lost_q, ts: rec_ts, sig: rec_sig};

  always_ff @(posedge clk) begin
    if (rst)        lost_q <= 1'b0;
    else if (rec_v) lost_q <= full;
  end

  hs_rec_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_rec),
    .rd_en_i(rd_en), .rd_data_o(rd_word), .full_o(full), .empty_o(empty)
  );

  seq_state_e       st_q;
  logic [REC_W-1:0] sh_q;
  logic [2:0]       idx_q;
  logic             ustart_q, ubusy;
  logic [7:0]       ubyte_q;

  assign rd_en = (st_q == SQ_IDLE) && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SQ_IDLE;
      sh_q     <= '0;
      idx_q    <= '0;
      ustart_q <= 1'b0;
      ubyte_q  <= '0;
    end else begin
      ustart_q <= 1'b0;
      case (st_q)
        SQ_IDLE:  if (!empty) st_q <= SQ_FETCH;
        SQ_FETCH: begin
          sh_q  <= rd_word;
          idx_q <= '0;
          st_q  <= SQ_SEND;
        end
        SQ_SEND: begin
          ustart_q <= 1'b1;
          ubyte_q  <= sh_q[REC_W-1 -: 8];
          sh_q     <= {sh_q[REC_W-9:0], 8'h00};
          st_q     <= SQ_WAIT;
        end
        SQ_WAIT: if (!ustart_q && !ubusy) begin
          if (idx_q == 3'(REC_BYTES - 1)) st_q <= SQ_IDLE;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= SQ_SEND;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  hs_uart_tx #(.BAUD_DIV(BAUD_DIV)) i_uart (
    .clk(clk), .rst(rst), .start_i(ustart_q), .data_i(ubyte_q),
    .tx_o(tx_o), .busy_o(ubusy)
  );

  // R6: a record is only fetched from an idle sequencer
  assert_fetch_from_idle_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (st_q == SQ_FETCH));
endmodule

// File: tb/test_hs_trace_top.sv
module test_hs_trace_top;
  localparam int CPU = 50;
  localparam int BD  = 8;
  localparam int DEP = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] rdy = '0;
  logic [3:0] blk = '0;
  logic       tx;

  always #10 clk = ~clk;

  hs_trace_top #(.NUM_BR(4), .CLK_PER_US(CPU), .BAUD_DIV(BD), .FIFO_DEPTH(DEP)) i_hs_trace_top (
    .clk(clk), .rst(rst), .rdy_i(rdy), .blk_i(blk), .tx_o(tx)
  );

  int cyc = 0;
  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  int errs = 0, checks = 0;
  bit done = 0;
  logic [39:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(bit ok, string req, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: change lines mid-microsecond m, so instant m sees the new value
  task automatic drive(int m, logic [3:0] r, logic [3:0] b, bit rec, bit ovf, string tag);
    while (cyc < m*CPU + 20) @(negedge clk);
    rdy = r;
    blk = b;
    if (rec) begin
      exp_q.push_back({ovf, 31'(m), b, r});
      tag_q.push_back(tag);
    end
  endtask

  // Monitor: decode serial bytes, assemble records, compare with scoreboard
  initial begin : monitor
    logic [39:0] got;
    logic [7:0]  byt;
    got = '0;
    byt = '0;
    @(negedge rst);
    forever begin
      for (int k = 0; k < 5; k++) begin
        while (tx !== 1'b0) @(negedge clk);
        repeat (BD/2) @(negedge clk);
        chk(tx == 1'b0, "R5 start bit", 40'(tx), 40'h0);
        for (int b = 0; b < 8; b++) begin
          repeat (BD) @(negedge clk);
          byt[b] = tx;
        end
        repeat (BD) @(negedge clk);
        chk(tx == 1'b1, "R5 stop bit", 40'(tx), 40'h1);
        got = {got[31:0], byt};
      end
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected record", got, 40'h0);
      end else begin
        logic [39:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got == e, t, got, e);
      end
    end
  end

  initial begin : watchdog
    repeat (40000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : main
    bit idle_ok;
    repeat (5) @(negedge clk);
    chk(tx == 1'b1, "R1 reset level", 40'(tx), 40'h1);
    rst = 1'b0;
    idle_ok = 1'b1;
    repeat (80) begin
      @(negedge clk);
      if (tx !== 1'b1) idle_ok = 1'b0;
    end
    chk(idle_ok, "R1 idle without change", 40'(idle_ok), 40'h1);

    // R3 first change vs zero, R2/R4 timestamp and layout
    drive(2, 4'b0001, 4'b0000, 1, 0, "R2 R3 R4 first record");
    drive(3, 4'b0001, 4'b0000, 0, 0, "");
    drive(4, 4'b1010, 4'b0101, 1, 0, "R4 mixed lines");
    drive(5, 4'b1010, 4'b0101, 0, 0, "");
    drive(6, 4'b0000, 4'b1000, 1, 0, "R6 ordering");

    // R7 burst: one in flight, DEP queued, rest dropped
    for (int i = 0; i < 7; i++) begin
      drive(40 + i, 4'(i), ~4'(i), (i < 1 + DEP), 0, "R6 burst record");
    end
    drive(100, 4'b1111, 4'b1111, 1, 1, "R7 overflow flag set");
    drive(110, 4'b0000, 4'b0000, 1, 0, "R7 flag cleared");

    while (cyc < 130*CPU) @(negedge clk);
    chk(exp_q.size() == 0, "R3 R6 all records delivered", 40'(exp_q.size()), 40'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule